// File: doc/BRIEF.md
# SD Command Issue Registers

This block is the command-side register front end of an SD host controller. Software fills in a 32-bit command argument, a transfer-mode word, a block size and a block count. It then writes the command word. A write that touches the upper byte of the command word is the trigger. If the controller is idle, that write launches the command. The block raises a one-cycle launch strobe toward a downstream command engine. Alongside the strobe it presents a captured copy of every field the engine needs. These fields are the command index, the response kind with its decoded flags, the check enables, the data-present flag, the transfer-mode controls, the argument, the block size and the block count.

Two busy flags track outstanding work, and software can read them back as a present-state word. The command-busy flag covers the command phase and clears when the engine reports that the command has finished. The data-busy flag covers the data phase of commands that carry data and clears when the engine reports that the transfer has finished. While either flag is set, a write to the command word is refused in full. Writes to the lower byte alone only edit fields and never launch.

Top module: `sdci_cmd_issue`

## Requirements
- R1: After reset every register reads zero, both busy flags are clear and the launch strobe is low.
- R2: Writes honour the byte enables: `wr_be[0]` updates bits 7:0 and `wr_be[1]` updates bits 15:8 of the selected word. Register words are at `wr_addr` 0 (argument bits 15:0), 1 (argument bits 31:16), 2 (block size), 3 (block count), 4 (transfer mode), 5 (command) and 6 (present state, read-only). Reserved bits read zero: the transfer mode keeps only mask 0x0037 and the command word keeps only mask 0x3F3B.
- R3: The block size holds 12 bits and the block count holds 9 bits. Higher written bits are dropped, so writing 0xFFFF reads back 0x0FFF and 0x01FF.
- R4: A write with `wr_be[1]` set to word 5 while both busy flags are clear raises `issue_go` for exactly one cycle, in the cycle after the write. The issue outputs carry the register contents as they stand after that write, and they hold their values until the next launch.
- R5: A write to word 5 with only `wr_be[0]` set updates the command's lower byte and produces no launch.
- R6: The command-busy flag sets with a launch and clears one cycle after `cmd_done` is seen high.
- R7: The data-busy flag sets with a launch only when the data-present bit (bit 5 of the command word) is set, and clears one cycle after `xfer_done` is seen high.
- R8: A trigger write while either busy flag is set produces no launch and leaves the command word unchanged.
- R9: The command word maps as follows: bits 13:8 hold the index, bit 3 enables the CRC check, bit 4 enables the index check, bit 5 selects data present, and bits 1:0 hold the response kind. The response kind codes are 0 for no response, 1 for 136-bit, 2 for 48-bit and 3 for 48-bit with busy. The decoded flags `issue_rsp_none`, `issue_rsp_long` and `issue_rsp_busy` are high for codes 0, 1 and 3 respectively.
- R10: The transfer mode maps as follows: bit 0 enables DMA, bit 1 enables the block count, bit 2 enables the automatic stop command, bit 4 selects the read direction, and bit 5 selects multi-block. Word 6 reads command-busy in bit 0 and data-busy in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write request |
| wr_addr | input | ADDR_W | Word select for writes |
| wr_be | input | 2 | Byte enables for writes |
| wr_data | input | 16 | Write data |
| rd_addr | input | ADDR_W | Word select for reads |
| rd_data | output | 16 | Read data (combinational) |
| cmd_done | input | 1 | Command phase finished, from the engine |
| xfer_done | input | 1 | Data phase finished, from the engine |
| cmd_inhibit | output | 1 | Command-busy flag |
| dat_inhibit | output | 1 | Data-busy flag |
| issue_go | output | 1 | One-cycle launch strobe |
| issue_index | output | 6 | Captured command index |
| issue_rsp_kind | output | 2 | Captured response kind code |
| issue_rsp_none | output | 1 | Response kind is no response |
| issue_rsp_long | output | 1 | Response kind is 136-bit |
| issue_rsp_busy | output | 1 | Response kind is 48-bit with busy |
| issue_crc_chk | output | 1 | CRC check enable |
| issue_idx_chk | output | 1 | Index check enable |
| issue_has_data | output | 1 | Data present select |
| issue_read | output | 1 | Read direction |
| issue_cnt_en | output | 1 | Block count enable |
| issue_multi | output | 1 | Multi-block select |
| issue_auto_stop | output | 1 | Automatic stop-command enable |
| issue_dma | output | 1 | DMA enable |
| issue_arg | output | 32 | Captured argument |
| issue_blk_size | output | BSZ_W | Captured block size |
| issue_blk_cnt | output | BCNT_W | Captured block count |

## Verification
The hardest case to reach is a refused trigger while only the data-busy flag is still set. The command phase must already be finished while the data phase is still outstanding. The stimulus creates this by launching a command with data present and then pulsing `cmd_done` alone. It then writes a new command word and confirms three things: no strobe appears, the old command word reads back unchanged, and the present-state word reads 2. Only after `xfer_done` does a further trigger launch.

// File: rtl/sdci_pkg.sv
package sdci_pkg;

    // register word indices
    localparam int REG_ARG_LO = 0;
    localparam int REG_ARG_HI = 1;
    localparam int REG_BSZ    = 2;
    localparam int REG_BCNT   = 3;
    localparam int REG_MODE   = 4;
    localparam int REG_CMD    = 5;
    localparam int REG_STATE  = 6;

    localparam logic [15:0] MODE_MASK = 16'h0037;
    localparam logic [15:0] CMD_MASK  = 16'h3F3B;

    typedef enum logic [1:0] {
        RSP_NONE       = 2'd0,
        RSP_LONG       = 2'd1,
        RSP_SHORT      = 2'd2,
        RSP_SHORT_BUSY = 2'd3
    } rsp_kind_e;

    typedef struct packed {
        logic [1:0] rsv_hi;
        logic [5:0] index;
        logic [1:0] rsv_mid;
        logic       data_sel;
        logic       idx_chk;
        logic       crc_chk;
        logic       rsv_lo;
        rsp_kind_e  kind;
    } cmd_word_t;

    typedef struct packed {
        logic [9:0] rsv_hi;
        logic       multi;
        logic       read;
        logic       rsv_mid;
        logic       auto_stop;
        logic       cnt_en;
        logic       dma;
    } mode_word_t;

    function automatic logic [15:0] merge_bytes(input logic [15:0] old_v,
                                                input logic [15:0] new_v,
                                                input logic [1:0]  be);
        logic [15:0] r;
        r = old_v;
        if (be[0]) r[7:0]  = new_v[7:0];
        if (be[1]) r[15:8] = new_v[15:8];
        return r;
    endfunction

endpackage

// File: rtl/sdci_regs.sv
module sdci_regs
    import sdci_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int BSZ_W  = 12,
    parameter int BCNT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_be,
    input  logic [15:0]       wr_data,
    input  logic              busy,
    output logic [31:0]       cur_arg,
    output logic [BSZ_W-1:0]  cur_bsz,
    output logic [BCNT_W-1:0] cur_bcnt,
    output mode_word_t        cur_mode,
    output cmd_word_t         cur_cmd,
    output logic [31:0]       nxt_arg,
    output logic [BSZ_W-1:0]  nxt_bsz,
    output logic [BCNT_W-1:0] nxt_bcnt,
    output mode_word_t        nxt_mode,
    output cmd_word_t         nxt_cmd
);

    typedef struct packed {
        logic [31:0]       arg;
        logic [BSZ_W-1:0]  bsz;
        logic [BCNT_W-1:0] bcnt;
        mode_word_t        mode;
        cmd_word_t         cmd;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        logic [15:0] m;
        m   = '0;
        s_d = s_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(REG_ARG_LO)) begin
                s_d.arg[15:0] = merge_bytes(s_q.arg[15:0], wr_data, wr_be);
            end else if (wr_addr == ADDR_W'(REG_ARG_HI)) begin
                s_d.arg[31:16] = merge_bytes(s_q.arg[31:16], wr_data, wr_be);
            end else if (wr_addr == ADDR_W'(REG_BSZ)) begin
                m = merge_bytes(16'(s_q.bsz), wr_data, wr_be);
                s_d.bsz = m[BSZ_W-1:0];
            end else if (wr_addr == ADDR_W'(REG_BCNT)) begin
                m = merge_bytes(16'(s_q.bcnt), wr_data, wr_be);
                s_d.bcnt = m[BCNT_W-1:0];
            end else if (wr_addr == ADDR_W'(REG_MODE)) begin
                m = merge_bytes(s_q.mode, wr_data, wr_be);
                s_d.mode = mode_word_t'(m & MODE_MASK);
            end else if (wr_addr == ADDR_W'(REG_CMD) && !busy) begin
                m = merge_bytes(s_q.cmd, wr_data, wr_be);
                s_d.cmd = cmd_word_t'(m & CMD_MASK);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_arg  = s_q.arg;
    assign cur_bsz  = s_q.bsz;
    assign cur_bcnt = s_q.bcnt;
    assign cur_mode = s_q.mode;
    assign cur_cmd  = s_q.cmd;
    assign nxt_arg  = s_d.arg;
    assign nxt_bsz  = s_d.bsz;
    assign nxt_bcnt = s_d.bcnt;
    assign nxt_mode = s_d.mode;
    assign nxt_cmd  = s_d.cmd;

endmodule

// File: rtl/sdci_launch.sv
module sdci_launch
    import sdci_pkg::*;
#(
    parameter int BSZ_W  = 12,
    parameter int BCNT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [31:0]       nxt_arg,
    input  logic [BSZ_W-1:0]  nxt_bsz,
    input  logic [BCNT_W-1:0] nxt_bcnt,
    input  mode_word_t        nxt_mode,
    input  cmd_word_t         nxt_cmd,
    input  logic              cmd_done,
    input  logic              xfer_done,
    output logic              busy,
    output logic              cmd_inh,
    output logic              dat_inh,
    output logic              go,
    output logic [31:0]       l_arg,
    output logic [BSZ_W-1:0]  l_bsz,
    output logic [BCNT_W-1:0] l_bcnt,
    output mode_word_t        l_mode,
    output cmd_word_t         l_cmd
);

    typedef struct packed {
        logic              cmd_inh;
        logic              dat_inh;
        logic              go;
        logic [31:0]       arg;
        logic [BSZ_W-1:0]  bsz;
        logic [BCNT_W-1:0] bcnt;
        mode_word_t        mode;
        cmd_word_t         cmd;
    } launch_t;

    launch_t s_d, s_q;
    logic    accept;

    assign busy   = s_q.cmd_inh | s_q.dat_inh;
    assign accept = trig & ~busy;

    always_comb begin
        s_d    = s_q;
        s_d.go = accept;
        if (cmd_done)  s_d.cmd_inh = 1'b0;
        if (xfer_done) s_d.dat_inh = 1'b0;
        if (accept) begin
            s_d.cmd_inh = 1'b1;
            s_d.dat_inh = nxt_cmd.data_sel;
            s_d.arg     = nxt_arg;
            s_d.bsz     = nxt_bsz;
            s_d.bcnt    = nxt_bcnt;
            s_d.mode    = nxt_mode;
            s_d.cmd     = nxt_cmd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_inh = s_q.cmd_inh;
    assign dat_inh = s_q.dat_inh;
    assign go      = s_q.go;
    assign l_arg   = s_q.arg;
    assign l_bsz   = s_q.bsz;
    assign l_bcnt  = s_q.bcnt;
    assign l_mode  = s_q.mode;
    assign l_cmd   = s_q.cmd;

endmodule

// File: rtl/sdci_rsp_decode.sv
module sdci_rsp_decode
    import sdci_pkg::*;
(
    input  rsp_kind_e kind,
    output logic      rsp_none,
    output logic      rsp_long,
    output logic      rsp_busy
);

    always_comb begin
        rsp_none = 1'b0;
        rsp_long = 1'b0;
        rsp_busy = 1'b0;
        unique case (kind)
            RSP_NONE:       rsp_none = 1'b1;
            RSP_LONG:       rsp_long = 1'b1;
            RSP_SHORT:      ;
            RSP_SHORT_BUSY: rsp_busy = 1'b1;
            default:        ;
        endcase
    end

endmodule

// File: rtl/sdci_cmd_issue.sv
module sdci_cmd_issue
    import sdci_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int BSZ_W  = 12,
    parameter int BCNT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_be,
    input  logic [15:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data,
    input  logic              cmd_done,
    input  logic              xfer_done,
    output logic              cmd_inhibit,
    output logic              dat_inhibit,
    output logic              issue_go,
    output logic [5:0]        issue_index,
    output logic [1:0]        issue_rsp_kind,
    output logic              issue_rsp_none,
    output logic              issue_rsp_long,
    output logic              issue_rsp_busy,
    output logic              issue_crc_chk,
    output logic              issue_idx_chk,
    output logic              issue_has_data,
    output logic              issue_read,
    output logic              issue_cnt_en,
    output logic              issue_multi,
    output logic              issue_auto_stop,
    output logic              issue_dma,
    output logic [31:0]       issue_arg,
    output logic [BSZ_W-1:0]  issue_blk_size,
    output logic [BCNT_W-1:0] issue_blk_cnt
);

    logic              busy, trig;
    logic [31:0]       cur_arg, nxt_arg;
    logic [BSZ_W-1:0]  cur_bsz, nxt_bsz;
    logic [BCNT_W-1:0] cur_bcnt, nxt_bcnt;
    mode_word_t        cur_mode, nxt_mode, l_mode;
    cmd_word_t         cur_cmd, nxt_cmd, l_cmd;

    assign trig = wr_en & wr_be[1] & (wr_addr == ADDR_W'(REG_CMD));

    sdci_regs #(.ADDR_W(ADDR_W), .BSZ_W(BSZ_W), .BCNT_W(BCNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_be(wr_be), .wr_data(wr_data), .busy(busy),
        .cur_arg(cur_arg), .cur_bsz(cur_bsz), .cur_bcnt(cur_bcnt),
        .cur_mode(cur_mode), .cur_cmd(cur_cmd),
        .nxt_arg(nxt_arg), .nxt_bsz(nxt_bsz), .nxt_bcnt(nxt_bcnt),
        .nxt_mode(nxt_mode), .nxt_cmd(nxt_cmd)
    );

    sdci_launch #(.BSZ_W(BSZ_W), .BCNT_W(BCNT_W)) u_launch (
        .clk(clk), .rst_n(rst_n), .trig(trig),
        .nxt_arg(nxt_arg), .nxt_bsz(nxt_bsz), .nxt_bcnt(nxt_bcnt),
        .nxt_mode(nxt_mode), .nxt_cmd(nxt_cmd),
        .cmd_done(cmd_done), .xfer_done(xfer_done),
        .busy(busy), .cmd_inh(cmd_inhibit), .dat_inh(dat_inhibit),
        .go(issue_go), .l_arg(issue_arg), .l_bsz(issue_blk_size),
        .l_bcnt(issue_blk_cnt), .l_mode(l_mode), .l_cmd(l_cmd)
    );

    sdci_rsp_decode u_dec (
        .kind(l_cmd.kind), .rsp_none(issue_rsp_none),
        .rsp_long(issue_rsp_long), .rsp_busy(issue_rsp_busy)
    );

    assign issue_index     = l_cmd.index;
    assign issue_rsp_kind  = l_cmd.kind;
    assign issue_crc_chk   = l_cmd.crc_chk;
    assign issue_idx_chk   = l_cmd.idx_chk;
    assign issue_has_data  = l_cmd.data_sel;
    assign issue_read      = l_mode.read;
    assign issue_cnt_en    = l_mode.cnt_en;
    assign issue_multi     = l_mode.multi;
    assign issue_auto_stop = l_mode.auto_stop;
    assign issue_dma       = l_mode.dma;

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(REG_ARG_LO))      rd_data = cur_arg[15:0];
        else if (rd_addr == ADDR_W'(REG_ARG_HI)) rd_data = cur_arg[31:16];
        else if (rd_addr == ADDR_W'(REG_BSZ))    rd_data = 16'(cur_bsz);
        else if (rd_addr == ADDR_W'(REG_BCNT))   rd_data = 16'(cur_bcnt);
        else if (rd_addr == ADDR_W'(REG_MODE))   rd_data = cur_mode;
        else if (rd_addr == ADDR_W'(REG_CMD))    rd_data = cur_cmd;
        else if (rd_addr == ADDR_W'(REG_STATE))  rd_data = {14'd0, dat_inhibit, cmd_inhibit};
    end

endmodule

// File: rtl/sdci_cmd_issue_chk.sv
module sdci_cmd_issue_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [1:0]        wr_be,
    input logic              cmd_done,
    input logic              xfer_done,
    input logic              cmd_inhibit,
    input logic              dat_inhibit,
    input logic              issue_go,
    input logic              issue_has_data,
    input logic [5:0]        issue_index,
    input logic [1:0]        issue_rsp_kind,
    input logic              issue_rsp_none,
    input logic              issue_rsp_long,
    input logic              issue_rsp_busy
);

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_go |=> !issue_go);

    p_fields_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_go |-> ($stable(issue_index) && $stable(issue_rsp_kind)));

    p_go_sets_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_go |-> cmd_inhibit);

    p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_inhibit && cmd_done) |=> !cmd_inhibit);

    p_data_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_go |-> (dat_inhibit == issue_has_data));

    p_xfer_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_inhibit && xfer_done) |=> !dat_inhibit);

    p_blocked_trigger_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[1] && wr_addr == ADDR_W'(5) && (cmd_inhibit || dat_inhibit))
        |=> !issue_go);

    p_launch_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        issue_go |-> $past(!cmd_inhibit && !dat_inhibit));

    p_rsp_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({issue_rsp_none, issue_rsp_long, issue_rsp_busy}) <= 1)
        && (issue_rsp_long == (issue_rsp_kind == 2'd1)));

endmodule

bind sdci_cmd_issue sdci_cmd_issue_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_sdci_cmd_issue.sv
module test_sdci_cmd_issue;

    localparam int ADDR_W = 3;
    localparam int BSZ_W  = 12;
    localparam int BCNT_W = 9;

    typedef struct packed {
        logic [15:0] cmd;
        logic [15:0] mode;
        logic [31:0] arg;
        logic [15:0] bsz;
        logic [15:0] bcnt;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{16'h0000, 16'h0000, 32'h0000_0000, 16'h0000, 16'h0000},
        '{16'h0209, 16'h0000, 32'h1234_5678, 16'h0000, 16'h0000},
        '{16'h113A, 16'h0012, 32'h0000_0400, 16'h0200, 16'h0001},
        '{16'h193B, 16'h0027, 32'hCAFE_0001, 16'h0200, 16'h0008},
        '{16'h3F1B, 16'h0000, 32'hFFFF_FFFF, 16'h0040, 16'h01FF}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [1:0]        wr_be = '0;
    logic [15:0]       wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [15:0]       rd_data;
    logic              cmd_done = 1'b0;
    logic              xfer_done = 1'b0;
    logic              cmd_inhibit, dat_inhibit, issue_go;
    logic [5:0]        issue_index;
    logic [1:0]        issue_rsp_kind;
    logic              issue_rsp_none, issue_rsp_long, issue_rsp_busy;
    logic              issue_crc_chk, issue_idx_chk, issue_has_data;
    logic              issue_read, issue_cnt_en, issue_multi, issue_auto_stop, issue_dma;
    logic [31:0]       issue_arg;
    logic [BSZ_W-1:0]  issue_blk_size;
    logic [BCNT_W-1:0] issue_blk_cnt;

    int total = 0;
    int bad = 0;
    logic [15:0] rv;

    always #10 clk = ~clk;

    sdci_cmd_issue #(.ADDR_W(ADDR_W), .BSZ_W(BSZ_W), .BCNT_W(BCNT_W)) i_sdci_cmd_issue (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_be(wr_be), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cmd_done(cmd_done), .xfer_done(xfer_done),
        .cmd_inhibit(cmd_inhibit), .dat_inhibit(dat_inhibit), .issue_go(issue_go),
        .issue_index(issue_index), .issue_rsp_kind(issue_rsp_kind),
        .issue_rsp_none(issue_rsp_none), .issue_rsp_long(issue_rsp_long),
        .issue_rsp_busy(issue_rsp_busy), .issue_crc_chk(issue_crc_chk),
        .issue_idx_chk(issue_idx_chk), .issue_has_data(issue_has_data),
        .issue_read(issue_read), .issue_cnt_en(issue_cnt_en),
        .issue_multi(issue_multi), .issue_auto_stop(issue_auto_stop),
        .issue_dma(issue_dma), .issue_arg(issue_arg),
        .issue_blk_size(issue_blk_size), .issue_blk_cnt(issue_blk_cnt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, hold across one rising edge
    task automatic wr(input int a, input logic [1:0] be, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        rd_addr = ADDR_W'(a);
        #1;
        d = rd_data;
    endtask

    task automatic pulse_done(input logic c, input logic x);
        cmd_done = c; xfer_done = x;
        @(negedge clk);
        cmd_done = 1'b0; xfer_done = 1'b0;
    endtask

    initial begin
        #(20 * 20000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            rd(a, rv);
            check("R1 reg zero", 32'(rv), 32'h0);
        end
        check("R1 flags", {29'd0, cmd_inhibit, dat_inhibit, issue_go}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: R4 R9 R10 R6 R7
        for (int i = 0; i < 5; i++) begin
            vec_t v;
            logic [1:0] k;
            v = VECS[i];
            k = v.cmd[1:0];
            wr(0, 2'b11, v.arg[15:0]);
            wr(1, 2'b11, v.arg[31:16]);
            wr(2, 2'b11, v.bsz);
            wr(3, 2'b11, v.bcnt);
            wr(4, 2'b11, v.mode);
            check("R4 no go before trigger", 32'(issue_go), 32'h0);
            wr(5, 2'b11, v.cmd);
            check("R4 go after trigger", 32'(issue_go), 32'h1);
            check("R9 index", 32'(issue_index), 32'(v.cmd[13:8]));
            check("R9 rsp kind", 32'(issue_rsp_kind), 32'(k));
            check("R9 rsp flags", {29'd0, issue_rsp_none, issue_rsp_long, issue_rsp_busy},
                  {29'd0, k == 2'd0, k == 2'd1, k == 2'd3});
            check("R9 checks", {29'd0, issue_crc_chk, issue_idx_chk, issue_has_data},
                  {29'd0, v.cmd[3], v.cmd[4], v.cmd[5]});
            check("R10 mode", {27'd0, issue_dma, issue_cnt_en, issue_auto_stop, issue_read, issue_multi},
                  {27'd0, v.mode[0], v.mode[1], v.mode[2], v.mode[4], v.mode[5]});
            check("R4 arg", issue_arg, v.arg);
            check("R4 size/count", {issue_blk_size, 11'd0, issue_blk_cnt},
                  {v.bsz[BSZ_W-1:0], 11'd0, v.bcnt[BCNT_W-1:0]});
            check("R6 cmd busy set", 32'(cmd_inhibit), 32'h1);
            check("R7 data busy", 32'(dat_inhibit), 32'(v.cmd[5]));
            @(negedge clk);
            check("R4 single pulse", 32'(issue_go), 32'h0);
            check("R4 hold", 32'(issue_index), 32'(v.cmd[13:8]));
            check("R6 still busy", 32'(cmd_inhibit), 32'h1);
            pulse_done(1'b1, 1'b1);
            check("R6 R7 cleared", {30'd0, cmd_inhibit, dat_inhibit}, 32'h0);
        end

        // R3 width limits
        wr(2, 2'b11, 16'hFFFF);
        rd(2, rv); check("R3 size width", 32'(rv), 32'h0FFF);
        wr(3, 2'b11, 16'hFFFF);
        rd(3, rv); check("R3 count width", 32'(rv), 32'h01FF);

        // R2 byte enables and reserved bits
        wr(0, 2'b11, 16'h1234);
        wr(0, 2'b10, 16'hFF00);
        rd(0, rv); check("R2 upper byte only", 32'(rv), 32'hFF34);
        wr(1, 2'b01, 16'hAAEE);
        rd(1, rv); check("R2 lower byte only", 32'(rv), 32'hFFEE);
        wr(4, 2'b11, 16'hFFFF);
        rd(4, rv); check("R2 mode mask", 32'(rv), 32'h0037);

        // R5 lower-byte command write
        wr(5, 2'b01, 16'hFF3A);
        check("R5 no go", 32'(issue_go), 32'h0);
        check("R5 not busy", 32'(cmd_inhibit), 32'h0);
        rd(5, rv); check("R5 lower updated", 32'(rv), 32'h3F3A);

        // R2 command mask via a full trigger
        wr(5, 2'b11, 16'hFFFF);
        rd(5, rv); check("R2 cmd mask", 32'(rv), 32'h3F3B);
        check("R4 go full word", 32'(issue_go), 32'h1);
        pulse_done(1'b1, 1'b1);

        // R8 refused while only data busy remains
        wr(5, 2'b11, 16'h0720);
        check("R7 data set", 32'(dat_inhibit), 32'h1);
        pulse_done(1'b1, 1'b0);
        rd(6, rv); check("R10 state data only", 32'(rv), 32'h2);
        wr(5, 2'b11, 16'h0502);
        check("R8 no go data busy", 32'(issue_go), 32'h0);
        rd(5, rv); check("R8 cmd unchanged", 32'(rv), 32'h0720);
        pulse_done(1'b0, 1'b1);
        rd(6, rv); check("R10 state idle", 32'(rv), 32'h0);
        wr(5, 2'b11, 16'h0502);
        check("R8 go after idle", 32'(issue_go), 32'h1);
        check("R7 no data no busy", 32'(dat_inhibit), 32'h0);
        rd(6, rv); check("R10 state cmd only", 32'(rv), 32'h1);

        // R8 refused while command busy
        wr(5, 2'b11, 16'h0902);
        check("R8 no go cmd busy", 32'(issue_go), 32'h0);
        check("R8 fields kept", 32'(issue_index), 32'h5);
        rd(5, rv); check("R8 cmd kept", 32'(rv), 32'h0502);
        pulse_done(1'b1, 1'b0);
        check("R6 cleared", 32'(cmd_inhibit), 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule